// File: doc/BRIEF.md
# Stream Packet Sum Loopback

This block sits between the outgoing and incoming stream ports of a DMA engine and acts as a simple data producer and consumer. It accepts a packet of a fixed number of 32-bit words on its stream input and adds every word into a running total. Once the whole packet has arrived, it sends that total back on its stream output as a packet with the same number of beats.

Every output beat carries the same total. The final output beat is marked with TLAST, so a stream-to-memory DMA can see where the packet ends. Packet boundaries on the input side come from a beat count set by a parameter, not from the input TLAST. Both ports use the usual valid/ready handshake and honour backpressure. The input side is closed while a result is being sent, so packets are handled strictly one after another.

Top module: `stream_sum_loop`

## Requirements
- R1: While `aresetn` is low, and on the first cycle after it goes high, `m_tvalid` and `m_tlast` are low and `s_tready` is high.
- R2: No output beat is offered until `PKT_LEN` input beats have been accepted. `s_tready` is low whenever `m_tvalid` is high, so the next packet is accepted only after the last output beat has been handshaken.
- R3: The output value is the sum of the packet's words modulo 2^32. Overflow wraps and is not saturated.
- R4: Each result is sent as exactly `PKT_LEN` output beats, and all of them carry the same value.
- R5: `m_tlast` is high on the `PKT_LEN`-th beat of each output packet and low on every other beat.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` do not change.
- R7: `s_tlast` is ignored. An input packet always ends at the `PKT_LEN`-th accepted beat, whatever `s_tlast` shows.
- R8: The total restarts from zero with each new input packet, so a packet's result does not depend on earlier packets.
- R9: With the default `PKT_LEN` of 8, the input words 0 to 7 produce eight output beats of 0x0000001C.
- R10: A beat counts only in a cycle where valid and ready are both high. Idle cycles with `s_tvalid` low do not advance the input count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aclk | input | 1 | Clock; all state changes on its rising edge |
| aresetn | input | 1 | Synchronous reset, active low |
| s_tdata | input | 32 | Input word |
| s_tvalid | input | 1 | Input word is valid |
| s_tready | output | 1 | Block accepts an input word |
| s_tlast | input | 1 | Input end marker, ignored |
| m_tdata | output | 32 | Packet sum |
| m_tvalid | output | 1 | Output beat is valid |
| m_tready | input | 1 | Downstream accepts the output beat |
| m_tlast | output | 1 | Marks the final beat of the output packet |

## Verification
The first output beat appears one clock after the edge that accepts the last input word. After that, each later beat follows one edge after the previous beat was handshaken. `s_tready` comes back one edge after the final output handshake. The bench drives inputs just after a rising edge and reads outputs at the falling edge, so each comparison sees the value that the next rising edge will consume. The scoreboard queues the expected beats before the packet is driven, and pops one entry only in a cycle where the monitor sees both valid and ready. Because of this, stalls and idle gaps move when a result arrives but never change the order in which results are compared.

// File: rtl/sum_loop_pkg.sv
package sum_loop_pkg;
  parameter int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {PH_RECV = 1'b0, PH_SEND = 1'b1} phase_e;

  // modulo 2^WORD_W addition used by the accumulator
  function automatic word_t wrap_add(input word_t a, input word_t b);
    return a + b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction
endpackage

// File: rtl/sum_beat_counter.sv
module sum_beat_counter #(
  parameter int unsigned LEN = 8,
  localparam int unsigned CW = sum_loop_pkg::cnt_width(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (step)
      cnt <= at_last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sum_accum.sv
module sum_accum
  import sum_loop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  first,
  input  word_t din,
  output word_t acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      acc <= '0;
    else if (take)
      acc <= wrap_add(first ? word_t'(0) : acc, din);
  end
endmodule

// File: rtl/sum_phase_ctrl.sv
module sum_phase_ctrl
  import sum_loop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_done,
  input  logic   tx_done,
  output phase_e phase
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_RECV: if (rx_done) nxt = PH_SEND;
      PH_SEND: if (tx_done) nxt = PH_RECV;
      default: nxt = PH_RECV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_RECV;
    else        phase <= nxt;
  end
endmodule

// File: rtl/stream_sum_loop.sv
module stream_sum_loop
  import sum_loop_pkg::*;
#(
  parameter int unsigned PKT_LEN = 8
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [WORD_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);
  localparam int unsigned CW = cnt_width(PKT_LEN);

  phase_e        phase;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_last, tx_last;
  word_t         acc;

  // named handshake events, also observed by the checker
  logic s_fire, m_fire, rx_done, tx_done;

  assign s_tready = (phase == PH_RECV);
  assign m_tvalid = (phase == PH_SEND);
  assign s_fire   = s_tvalid & s_tready;
  assign m_fire   = m_tvalid & m_tready;
  assign rx_done  = s_fire & rx_last;
  assign tx_done  = m_fire & tx_last;
  assign m_tdata  = acc;
  assign m_tlast  = m_tvalid & tx_last;

  sum_beat_counter #(.LEN(PKT_LEN)) u_rx_cnt (
    .clk(aclk), .rst_n(aresetn), .step(s_fire), .cnt(rx_cnt), .at_last(rx_last)
  );

  sum_beat_counter #(.LEN(PKT_LEN)) u_tx_cnt (
    .clk(aclk), .rst_n(aresetn), .step(m_fire), .cnt(tx_cnt), .at_last(tx_last)
  );

  sum_accum u_acc (
    .clk(aclk), .rst_n(aresetn), .take(s_fire), .first(rx_cnt == '0),
    .din(s_tdata), .acc(acc)
  );

  sum_phase_ctrl u_phase (
    .clk(aclk), .rst_n(aresetn), .rx_done(rx_done), .tx_done(tx_done), .phase(phase)
  );
endmodule

// File: rtl/sum_loop_checker.sv
module sum_loop_checker #(
  parameter int unsigned PKT_LEN = 8,
  parameter int unsigned WORD_W  = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              s_tlast,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_tlast,
  input logic [WORD_W-1:0] m_tdata,
  input logic              s_fire,
  input logic              m_fire
);
  localparam int unsigned CW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PKT_LEN - 1);

  logic [CW-1:0] in_cnt, out_cnt;

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (s_fire)  in_cnt  <= (in_cnt  == LAST) ? '0 : in_cnt  + 1'b1;
      if (m_fire)  out_cnt <= (out_cnt == LAST) ? '0 : out_cnt + 1'b1;
    end
  end

  assert_reset_R1: assert property (@(posedge aclk)
    !aresetn |=> (!m_tvalid && !m_tlast && s_tready));

  assert_no_overlap_R2: assert property (@(posedge aclk) disable iff (!aresetn)
    !(s_tready && m_tvalid));

  assert_full_pkt_R2: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_fire && in_cnt == LAST) |=> m_tvalid);

  assert_same_value_R4: assert property (@(posedge aclk) disable iff (!aresetn)
    (m_fire && !m_tlast) |=> (m_tvalid && $stable(m_tdata)));

  assert_tlast_pos_R5: assert property (@(posedge aclk) disable iff (!aresetn)
    m_tvalid |-> (m_tlast == (out_cnt == LAST)));

  assert_hold_R6: assert property (@(posedge aclk) disable iff (!aresetn)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_tlast_ignored_R7: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_fire && s_tlast && in_cnt != LAST) |=> s_tready);

  assert_idle_no_count_R10: assert property (@(posedge aclk) disable iff (!aresetn)
    (!s_tvalid && s_tready) |=> (s_tready && $stable(in_cnt)));
endmodule

bind stream_sum_loop sum_loop_checker #(.PKT_LEN(PKT_LEN), .WORD_W(32)) u_chk (
  .aclk(aclk), .aresetn(aresetn), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .s_tlast(s_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
  .m_tdata(m_tdata), .s_fire(s_fire), .m_fire(m_fire)
);

// File: tb/sim_stream_sum_loop.sv
`timescale 1ns/1ps
module sim_stream_sum_loop;
  localparam int PKT = 8;
  typedef logic [31:0] pkt_t [PKT];

  logic        clk = 0;
  logic        aresetn = 0;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 0;
  logic        s_tlast = 0;
  logic        s_tready;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1;
  logic        m_tlast;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  mon_on = 0;
  bit  bp_on = 0;
  bit  done = 0;
  int  cycles = 0;

  logic [31:0] exp_data [$];
  bit          exp_last [$];

  always #2 clk = ~clk;   // 250 MHz

  stream_sum_loop #(.PKT_LEN(PKT)) u0 (
    .aclk(clk), .aresetn(aresetn), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tlast(s_tlast), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // backpressure generator
  always begin
    @(posedge clk); #1;
    m_tready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor / scoreboard
  bit          prev_stall = 0;
  logic [31:0] prev_data;
  bit          prev_last;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_stall) begin
        check(m_tvalid && m_tdata == prev_data && m_tlast == prev_last,
              "R6 hold under stall", m_tdata, prev_data);
      end
      if (m_tvalid && m_tready) begin
        check(!s_tready, "R2 input closed while sending", {31'd0, s_tready}, 32'd0);
        if (exp_data.size() == 0) begin
          check(0, "R4 unexpected extra beat", m_tdata, 32'd0);
        end else begin
          logic [31:0] ed;
          bit el;
          ed = exp_data.pop_front();
          el = exp_last.pop_front();
          check(m_tdata == ed, "R3/R4/R8 beat value", m_tdata, ed);
          check(m_tlast == el, "R5 tlast position", {31'd0, m_tlast}, {31'd0, el});
        end
      end
      prev_stall = m_tvalid && !m_tready;
      prev_data  = m_tdata;
      prev_last  = m_tlast;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      check(0, "watchdog", cycles, 50000);
      summary();
    end
  end

  // expects to start just after a rising edge; returns just after one
  task automatic drive_beat(input logic [31:0] d, input bit last);
    bit ok;
    s_tdata = d; s_tlast = last; s_tvalid = 1;
    do begin
      @(negedge clk); ok = s_tready;
      @(posedge clk); #1;
    end while (!ok);
    s_tvalid = 0; s_tlast = 0;
  endtask

  task automatic send_pkt(input pkt_t v, input bit noisy_last, input int gap, input bit hold_check);
    logic [31:0] sum = '0;
    for (int i = 0; i < PKT; i++) sum = sum + v[i];   // 32-bit wrap
    for (int i = 0; i < PKT; i++) begin
      exp_data.push_back(sum);
      exp_last.push_back(i == PKT - 1);
    end
    for (int i = 0; i < PKT; i++) begin
      if (gap > 0) begin
        s_tlast = $urandom_range(0, 1);
        repeat ($urandom_range(0, gap)) begin @(posedge clk); #1; end
      end
      drive_beat(v[i], noisy_last ? bit'($urandom_range(0, 1)) : bit'(i == PKT - 1));
      if (hold_check && i == PKT - 2) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check(!m_tvalid, "R2 no output before full packet", {31'd0, m_tvalid}, 32'd0);
        end
        @(posedge clk); #1;
      end
    end
  endtask

  initial begin
    pkt_t p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!m_tvalid && !m_tlast && s_tready, "R1 reset state",
          {29'd0, m_tvalid, m_tlast, s_tready}, 32'd1);
    @(posedge clk); #1;
    aresetn = 1;
    @(negedge clk);
    check(!m_tvalid && !m_tlast && s_tready, "R1 after reset release",
          {29'd0, m_tvalid, m_tlast, s_tready}, 32'd1);
    mon_on = 1;
    @(posedge clk); #1;

    // R9: words 0..7 give 0x1C on every beat; the bench sum is 28
    for (int i = 0; i < PKT; i++) p[i] = i;
    send_pkt(p, 0, 0, 1);

    // R3: wrap on overflow (8 * 0xF0000000 = 0x80000000 mod 2^32)
    for (int i = 0; i < PKT; i++) p[i] = 32'hF000_0000;
    send_pkt(p, 0, 0, 0);

    // R7, R10: random s_tlast, idle gaps, with backpressure (R6)
    bp_on = 1;
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < PKT; i++) p[i] = $urandom;
      send_pkt(p, 1, 3, 0);
    end

    // R8: back-to-back packets, each starting from zero
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < PKT; i++) p[i] = n * 100 + i;
      send_pkt(p, 0, 0, 0);
    end
    bp_on = 0;

    for (int k = 0; k < 500 && exp_data.size() != 0; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_data.size() == 0, "R4 all expected beats seen", exp_data.size(), 0);
    check(!m_tvalid && s_tready, "R2 idle after last packet",
          {30'd0, m_tvalid, s_tready}, 32'd1);
    summary();
  end
endmodule